// File: doc/BRIEF.md
# I2C SCL Clock Generator

This block produces the serial clock of an I2C master from the peripheral clock. It divides in two stages. A prescaler divides the peripheral clock by one plus a two-bit divide field, which gives an internal-clock enable. A period counter then runs the SCL period in internal-clock cycles: a fixed overhead of 20 cycles, plus 8 cycles for each unit of a six-bit step field, plus a rounding term that covers rise time, fall time and internal delay. That rounding term is a build parameter. The low phase gets the larger half of the period and the high phase gets the smaller half. The block pulls SCL low during the low phase and releases it for the high phase. It gives the master engine a one-cycle tick at each falling and rising edge it generates.

Both fields live in one configuration register that is written through a plain write strobe. A write changes the shadow copy only. The running configuration takes the shadow value when the next SCL period begins, so a write never shortens a pulse. The block watches the SCL line through a synchroniser. While the line stays low after release because a target is stretching the clock, high-phase counting stops. The block has no streaming data path, so none of its pins has a valid/ready handshake and nothing applies back-pressure. Setting `run` starts periods. Clearing `run` lets the current period finish and then leaves the line released.

Top module: `i2c_scl_clkgen`

## Requirements
- R1: After reset, `scl_drive_low`, `scl_fall`, `scl_rise`, `ick_tick` and `busy` are 0, and `cfg_q` is 0.
- R2: A cycle with `cfg_we` high stores `cfg_wdata` into `cfg_q`, visible from the next cycle. Bits 1:0 are the divide field D (0 to 3). Bits 7:2 are the step field S (0 to 63).
- R3: During a period, `ick_tick` pulses once every D+1 clock cycles. It does not pulse while high-phase counting is held. One period contains exactly P ticks.
- R4: The period length is P = 20 + 8*S + ROUND_CYC internal-clock cycles. SCL is driven low for ceil(P/2)*(D+1) clock cycles.
- R5: The high phase ends after floor(P/2) internal-clock cycles, counted once the synchronised line reads high. With no stretching, SCL is released for floor(P/2)*(D+1) + SYNC_STAGES clock cycles.
- R6: If a target keeps the line low for K cycles after release, the released time grows by exactly K cycles and no tick is counted during the hold.
- R7: A write made during a period has no effect on that period. It takes effect from the next falling edge.
- R8: With `run` high in idle, the next cycle begins a low phase. `scl_fall` is high only in the first cycle of each low phase and `scl_rise` is high only in the first cycle of each high phase.
- R9: Clearing `run` lets the current period finish. The line is then released, `busy` returns to 0 and no further falling edge is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Generate SCL periods while high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data: {step, divide} |
| scl_in | input | 1 | Sensed level of the SCL line |
| scl_drive_low | output | 1 | Pull SCL low (open-drain enable) |
| scl_fall | output | 1 | First cycle of a low phase |
| scl_rise | output | 1 | First cycle of a high phase |
| ick_tick | output | 1 | Internal-clock enable |
| busy | output | 1 | A period is in progress |
| cfg_q | output | 8 | Stored configuration value |

## Verification
The hardest case to reach is a high phase in which the line stays low after release, because the counter must freeze for exactly the stretch time and then resume with the prescaler restarted. The bench models the open-drain line with its own pull-up and a stretch counter that reloads while the block pulls low. This lets it hold the line low for a chosen number of cycles after each release and predict the lengthened high time arithmetically. The step field is swept over all 64 values at divide 0, and a set of steps is run at every other divide. Each write lands in the first low cycle of the period before the one it configures, so every period also shows that a mid-period write is deferred.

// File: rtl/i2c_scl_clkgen_pkg.sv
package i2c_scl_clkgen_pkg;

  typedef enum logic [1:0] {
    SCL_IDLE = 2'd0,
    SCL_LOW  = 2'd1,
    SCL_HIGH = 2'd2
  } scl_phase_e;

  // Longest period in internal-clock cycles for a given step width.
  function automatic int unsigned sclgen_period_max(input int unsigned step_w,
                                                    input int unsigned base,
                                                    input int unsigned mul,
                                                    input int unsigned rnd);
    return base + mul * ((1 << step_w) - 1) + rnd;
  endfunction

endpackage

// File: rtl/sclgen_sync.sv
module sclgen_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= 1'b1;
        else        sh_q <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= {sh_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/sclgen_cfg.sv
module sclgen_cfg #(
  parameter int unsigned PRE_W  = 2,
  parameter int unsigned STEP_W = 6,
  localparam int unsigned CFG_W = PRE_W + STEP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CFG_W-1:0]  wdata,
  input  logic              load,
  output logic [CFG_W-1:0]  shadow,
  output logic [STEP_W-1:0] step_new,
  output logic [PRE_W-1:0]  pre_act,
  output logic [STEP_W-1:0] step_act
);
  logic [CFG_W-1:0] shadow_q;
  logic [CFG_W-1:0] active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  shadow_q <= '0;
    else if (we) shadow_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    active_q <= '0;
    else if (load) active_q <= shadow_q;
  end

  assign shadow   = shadow_q;
  assign step_new = shadow_q[CFG_W-1:PRE_W];
  assign pre_act  = active_q[PRE_W-1:0];
  assign step_act = active_q[CFG_W-1:PRE_W];

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> shadow_q == $past(wdata));
endmodule

// File: rtl/sclgen_prescaler.sv
module sclgen_prescaler #(
  parameter int unsigned PRE_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hold,
  input  logic [PRE_W-1:0] div,
  output logic             tick
);
  logic [PRE_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run || hold)   cnt_q <= '0;
    else if (cnt_q == div)   cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign tick = run && !hold && (cnt_q == div);

  p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt_q <= div);
  p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (!tick || div == '0));
  p_no_tick_in_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !tick);
endmodule

// File: rtl/sclgen_phase_ctrl.sv
module sclgen_phase_ctrl
  import i2c_scl_clkgen_pkg::*;
#(
  parameter int unsigned STEP_W    = 6,
  parameter int unsigned BASE_CYC  = 20,
  parameter int unsigned STEP_CYC  = 8,
  parameter int unsigned ROUND_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              ick_tick,
  input  logic              scl_high,
  input  logic [STEP_W-1:0] step_new,
  input  logic [STEP_W-1:0] step_act,
  output logic              load_cfg,
  output logic              hold,
  output logic              scl_drive_low,
  output logic              scl_fall,
  output logic              scl_rise,
  output logic              busy
);
  localparam int unsigned PER_MAX =
    sclgen_period_max(STEP_W, BASE_CYC, STEP_CYC, ROUND_CYC);
  localparam int unsigned CNT_W = $clog2(PER_MAX + 2);

  scl_phase_e       phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fall_q, fall_d, rise_q, rise_d;
  logic [CNT_W-1:0] per_new, per_act, low_rl, high_rl;
  logic             last_tick, start_period;

  // Period length in internal-clock cycles for the next and current setting.
  assign per_new = CNT_W'(BASE_CYC) + CNT_W'(STEP_CYC) * CNT_W'(step_new)
                 + CNT_W'(ROUND_CYC);
  assign per_act = CNT_W'(BASE_CYC) + CNT_W'(STEP_CYC) * CNT_W'(step_act)
                 + CNT_W'(ROUND_CYC);
  // Low takes the odd cycle; reload values count down to zero.
  assign low_rl  = ((per_new + 1'b1) >> 1) - 1'b1;
  assign high_rl = (per_act >> 1) - 1'b1;

  assign last_tick    = ick_tick && (cnt_q == '0);
  assign start_period = ((phase_q == SCL_IDLE) && run) ||
                        ((phase_q == SCL_HIGH) && last_tick && run);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    fall_d  = 1'b0;
    rise_d  = 1'b0;
    unique case (phase_q)
      SCL_IDLE: begin
        if (run) begin
          phase_d = SCL_LOW;
          cnt_d   = low_rl;
          fall_d  = 1'b1;
        end
      end
      SCL_LOW: begin
        if (last_tick) begin
          phase_d = SCL_HIGH;
          cnt_d   = high_rl;
          rise_d  = 1'b1;
        end else if (ick_tick) begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      SCL_HIGH: begin
        if (last_tick) begin
          if (run) begin
            phase_d = SCL_LOW;
            cnt_d   = low_rl;
            fall_d  = 1'b1;
          end else begin
            phase_d = SCL_IDLE;
            cnt_d   = '0;
          end
        end else if (ick_tick) begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: begin
        phase_d = SCL_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= SCL_IDLE;
      cnt_q   <= '0;
      fall_q  <= 1'b0;
      rise_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      fall_q  <= fall_d;
      rise_q  <= rise_d;
    end
  end

  assign load_cfg      = start_period;
  assign hold          = (phase_q == SCL_HIGH) && !scl_high;
  assign scl_drive_low = (phase_q == SCL_LOW);
  assign scl_fall      = fall_q;
  assign scl_rise      = rise_q;
  assign busy          = (phase_q != SCL_IDLE);

  p_fall_marks_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_drive_low) |-> scl_fall);
  p_rise_marks_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_drive_low) && busy) |-> scl_rise);
  p_edges_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scl_fall, scl_rise}));
  p_hold_freezes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ($stable(cnt_q) && phase_q == SCL_HIGH));
  p_idle_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_drive_low && !scl_fall && !scl_rise));
endmodule

// File: rtl/i2c_scl_clkgen.sv
module i2c_scl_clkgen #(
  parameter int unsigned PRE_W       = 2,
  parameter int unsigned STEP_W      = 6,
  parameter int unsigned BASE_CYC    = 20,
  parameter int unsigned STEP_CYC    = 8,
  parameter int unsigned ROUND_CYC   = 3,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CFG_W      = PRE_W + STEP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             scl_in,
  output logic             scl_drive_low,
  output logic             scl_fall,
  output logic             scl_rise,
  output logic             ick_tick,
  output logic             busy,
  output logic [CFG_W-1:0] cfg_q
);
  logic              scl_high;
  logic              load_cfg;
  logic              hold;
  logic [STEP_W-1:0] step_new, step_act;
  logic [PRE_W-1:0]  pre_act;

  sclgen_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (scl_in),
    .q     (scl_high)
  );

  sclgen_cfg #(.PRE_W(PRE_W), .STEP_W(STEP_W)) i_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .wdata    (cfg_wdata),
    .load     (load_cfg),
    .shadow   (cfg_q),
    .step_new (step_new),
    .pre_act  (pre_act),
    .step_act (step_act)
  );

  sclgen_prescaler #(.PRE_W(PRE_W)) i_prescaler (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .hold  (hold),
    .div   (pre_act),
    .tick  (ick_tick)
  );

  sclgen_phase_ctrl #(
    .STEP_W    (STEP_W),
    .BASE_CYC  (BASE_CYC),
    .STEP_CYC  (STEP_CYC),
    .ROUND_CYC (ROUND_CYC)
  ) i_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .run           (run),
    .ick_tick      (ick_tick),
    .scl_high      (scl_high),
    .step_new      (step_new),
    .step_act      (step_act),
    .load_cfg      (load_cfg),
    .hold          (hold),
    .scl_drive_low (scl_drive_low),
    .scl_fall      (scl_fall),
    .scl_rise      (scl_rise),
    .busy          (busy)
  );

  p_cfg_frozen_in_period_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !scl_fall) |-> ($stable(pre_act) && $stable(step_act)));
endmodule

// File: tb/test_i2c_scl_clkgen.sv
module test_i2c_scl_clkgen;
  localparam int ROUND = 3;
  localparam int SYNC  = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic       scl_in;
  logic       scl_drive_low, scl_fall, scl_rise, ick_tick, busy;
  logic [7:0] cfg_q;

  int checks = 0;
  int errors = 0;
  int stretch_len = 0;
  int str_cnt = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  i2c_scl_clkgen i_i2c_scl_clkgen (
    .clk(clk), .rst_n(rst_n), .run(run), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .scl_in(scl_in), .scl_drive_low(scl_drive_low), .scl_fall(scl_fall),
    .scl_rise(scl_rise), .ick_tick(ick_tick), .busy(busy), .cfg_q(cfg_q)
  );

  // Open-drain line with pull-up and a target that stretches after release.
  always @(posedge clk) begin
    if (scl_drive_low) str_cnt <= stretch_len;
    else if (str_cnt != 0) str_cnt <= str_cnt - 1;
  end
  assign scl_in = !scl_drive_low && (str_cnt == 0);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int per_of(input logic [7:0] c);
    return 20 + 8 * int'(c[7:2]) + ROUND;
  endfunction

  // Entry: negedge in the first low cycle. Exit: next low start or idle.
  task automatic run_period(input logic [7:0] nxt, input bit wr,
                            output int lc, output int hc, output int tl,
                            output int th, output int rise_ok);
    lc = 0; hc = 0; tl = 0; th = 0; rise_ok = 0;
    if (wr) begin cfg_we = 1'b1; cfg_wdata = nxt; end
    while (scl_drive_low) begin
      lc++;
      if (ick_tick) tl++;
      @(negedge clk);
      cfg_we = 1'b0;
    end
    cfg_we = 1'b0;
    rise_ok = int'(scl_rise);
    while (!scl_drive_low && busy) begin
      hc++;
      if (ick_tick) th++;
      @(negedge clk);
    end
  endtask

  task automatic check_period(input logic [7:0] c, input int k,
                              input int lc, input int hc, input int tl,
                              input int th, input int rise_ok, input string tag);
    int p = per_of(c);
    int d = int'(c[1:0]) + 1;
    chk(lc, ((p + 1) / 2) * d, {tag, " R4 low cycles"});
    chk(hc, (p / 2) * d + SYNC + k, {tag, " R5 R6 high cycles"});
    chk(tl, (p + 1) / 2, {tag, " R3 low ticks"});
    chk(th, p / 2, {tag, " R3 R6 high ticks"});
    chk(rise_ok, 1, {tag, " R8 rise pulse"});
  endtask

  logic [7:0] seq [76];

  initial begin
    int lc, hc, tl, th, rk;
    int n;
    logic [7:0] cur;
    n = 0;
    for (int s = 0; s < 64; s++) begin seq[n] = {s[5:0], 2'd0}; n++; end
    for (int dv = 1; dv < 4; dv++) begin
      seq[n] = {6'd0, dv[1:0]};  n++;
      seq[n] = {6'd1, dv[1:0]};  n++;
      seq[n] = {6'd37, dv[1:0]}; n++;
      seq[n] = {6'd63, dv[1:0]}; n++;
    end

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(int'(scl_drive_low), 0, "R1 drive");
    chk(int'(scl_fall | scl_rise), 0, "R1 edge ticks");
    chk(int'(ick_tick), 0, "R1 ick_tick");
    chk(int'(busy), 0, "R1 busy");
    chk(int'(cfg_q), 0, "R1 cfg_q");
    rst_n = 1'b1;
    @(negedge clk);

    // R2 write while idle
    cfg_we = 1'b1; cfg_wdata = seq[0];
    @(negedge clk);
    cfg_we = 1'b0;
    chk(int'(cfg_q), int'(seq[0]), "R2 cfg_q after write");
    repeat (5) @(negedge clk);
    chk(int'(busy | scl_drive_low), 0, "R8 no period without run");

    // R8 start
    run = 1'b1;
    @(negedge clk);
    chk(int'(scl_drive_low & scl_fall), 1, "R8 start low with fall");

    // Sweep: each write lands in the period before it is used (R7)
    cur = seq[0];
    for (int i = 0; i < 76; i++) begin
      logic [7:0] nx;
      nx = (i + 1 < 76) ? seq[i + 1] : seq[i];
      run_period(nx, 1'b1, lc, hc, tl, th, rk);
      check_period(cur, 0, lc, hc, tl, th, rk, "sweep R7");
      chk(int'(scl_fall), 1, "R8 fall at period start");
      chk(int'(cfg_q), int'(nx), "R2 cfg_q holds written value");
      cur = nx;
    end

    // R6 stretching: line held low after release
    cur = 8'h14;
    run_period(cur, 1'b1, lc, hc, tl, th, rk);
    stretch_len = 5;
    run_period(cur, 1'b0, lc, hc, tl, th, rk);
    check_period(cur, 5, lc, hc, tl, th, rk, "stretch5 R6");
    stretch_len = 17;
    run_period(cur, 1'b0, lc, hc, tl, th, rk);
    check_period(cur, 17, lc, hc, tl, th, rk, "stretch17 R6");
    stretch_len = 0;
    run_period(cur, 1'b0, lc, hc, tl, th, rk);
    check_period(cur, 0, lc, hc, tl, th, rk, "no stretch R5");

    // R7 write later in the low phase, current period unaffected
    repeat (3) @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = 8'h09;
    @(negedge clk);
    cfg_we = 1'b0;
    begin
      int l2, h2, t2, u2, r2;
      run_period(8'h00, 1'b0, l2, h2, t2, u2, r2);
      chk(l2 + 4, ((per_of(cur) + 1) / 2) * 1, "R7 low unchanged by late write");
      chk(h2, (per_of(cur) / 2) + SYNC, "R7 high unchanged by late write");
    end
    run_period(8'h00, 1'b0, lc, hc, tl, th, rk);
    check_period(8'h09, 0, lc, hc, tl, th, rk, "R7 new setting next period");

    // R9 stop completes the period
    run = 1'b0;
    run_period(8'h00, 1'b0, lc, hc, tl, th, rk);
    check_period(8'h09, 0, lc, hc, tl, th, rk, "R9 final period");
    chk(int'(busy), 0, "R9 busy after stop");
    chk(int'(scl_drive_low), 0, "R9 released after stop");
    begin
      int falls = 0;
      for (int j = 0; j < 40; j++) begin
        if (scl_drive_low | scl_fall | busy) falls++;
        @(negedge clk);
      end
      chk(falls, 0, "R9 no edge while stopped");
    end

    // R8 restart from idle
    run = 1'b1;
    @(negedge clk);
    chk(int'(scl_drive_low & scl_fall), 1, "R8 restart low with fall");
    run_period(8'h00, 1'b0, lc, hc, tl, th, rk);
    check_period(8'h09, 0, lc, hc, tl, th, rk, "restart R4");
    run = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule